// File: doc/BRIEF.md
# Bridge Control and Status Register Bank

This block is the software-visible control and status register bank of a bus-to-PCIe bridge. A host reaches it through a simple register bus carrying a byte offset, byte enables, separate read and write strobes, write data and registered read data. Eight registers sit in a word-aligned window starting at byte offset 0x130. Each register has a fixed writable width, a set of read-only bits and a set of write-one-to-clear bits. A write merges only the bits that software may change and keeps all other bits.

Two of the registers form the interrupt path. The pending register collects hardware events, which arrive as one-cycle pulses on an event input vector, and software clears it by writing ones. The enable register selects which pending bits may raise the single level-sensitive interrupt output. That output is registered, and it is the OR of pending AND enable.

Top module: `bridge_csr_bank`

## Requirements
- R1: After reset the identity register reads 0x00070007, the link status/control register reads 0x00000800, every other register reads 0, and `irq` is 0.
- R2: Byte offsets map as follows: 0x130 identity, 0x134 control/status, 0x138 interrupt pending, 0x13C interrupt enable, 0x140 bus position, 0x144 link status/control, 0x14C MSI base low, 0x150 MSI base high.
- R3: A write changes only the writable bits and keeps every read-only bit, every write-one-to-clear bit and every bit at or above the register width. The writable masks are: identity none, control/status 0x00030100, interrupt enable 0x1FF30FEF, bus position 0x00FFFFFF, link status/control 0x003F0000, both MSI base registers 0xFFFFFFFF, interrupt pending none.
- R4: In the interrupt pending register, each bit in 0x1FF30FEF is cleared by writing 1 to it and is unchanged by writing 0. Every other pending bit always reads 0.
- R5: An event pulse on `evt_set[i]` sets pending bit i when bit i is in 0x1FF30FEF. Other event bits have no effect. When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: `irq` is the registered OR of (pending AND enable). It changes on the clock edge that follows the edge on which pending or enable changed.
- R7: `reg_rdata` is loaded on the clock edge that samples `reg_rd` and holds its value while `reg_rd` is low. A read issued in the same cycle as a write to the same register returns the value from before the write.
- R8: Offsets with no register (0x148 and 0x154 to 0x15C), offsets outside 0x130 to 0x15F, and offsets not aligned to 4 bytes read as 0, and writes to them change no register.
- R9: An access whose `reg_be` is not 4'hF is rejected: a write changes nothing and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_set | input | EVT_W | Event pulses that set interrupt pending bits |
| irq | output | 1 | Level interrupt request |

## Verification
A write takes effect at the clock edge that samples the strobe, so the bench checks it with a read whose data is sampled at the falling edge one cycle after the read strobe. Event pulses also show up in the pending register at the edge that samples them. `irq` follows any change of pending or enable exactly one edge later. The bench therefore checks the interrupt output twice: at the falling edge right after the write or event, where it must still show the old level, and one full cycle later, where it must show the new level. The hold check samples `reg_rdata` one cycle after a change of address with no strobe. The read-during-write check samples the old value in the cycle after the combined strobe.

// File: rtl/bcsr_pkg.sv
package bcsr_pkg;

  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 12;
  localparam int BASE_OFF = 32'h130;
  localparam int SLOT_W   = $clog2(NUM_REGS);

  // register slots (slot = (offset - BASE_OFF) / 4)
  localparam int IDX_IDENT  = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_PEND   = 2;
  localparam int IDX_EN     = 3;
  localparam int IDX_BUSPOS = 4;
  localparam int IDX_LINK   = 5;
  localparam int IDX_MSI_LO = 7;
  localparam int IDX_MSI_HI = 8;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic       present;
    logic [5:0] width;
    word_t      ro;
    word_t      w1c;
    word_t      rst;
  } reg_attr_t;

  function automatic reg_attr_t attr_of(int idx);
    reg_attr_t a;
    a = '0;
    case (idx)
      IDX_IDENT:  begin a.present = 1'b1; a.width = 6'd19; a.ro = '1;
                        a.rst = 32'h0007_0007; end
      IDX_CTRL:   begin a.present = 1'b1; a.width = 6'd18; a.ro = 32'h0000_FEFF; end
      IDX_PEND:   begin a.present = 1'b1; a.width = 6'd29; a.ro = 32'h000C_F010;
                        a.w1c = 32'h1FF3_0FEF; end
      IDX_EN:     begin a.present = 1'b1; a.width = 6'd29; a.ro = 32'h000C_F010; end
      IDX_BUSPOS: begin a.present = 1'b1; a.width = 6'd24; end
      IDX_LINK:   begin a.present = 1'b1; a.width = 6'd22; a.ro = 32'h0000_FFFF;
                        a.rst = 32'h0000_0800; end
      IDX_MSI_LO: begin a.present = 1'b1; a.width = 6'd32; end
      IDX_MSI_HI: begin a.present = 1'b1; a.width = 6'd32; end
      default:    a = '0;
    endcase
    return a;
  endfunction

  function automatic word_t width_mask(int w);
    word_t m;
    if (w >= DATA_W) m = '1;
    else m = (word_t'(1) << w) - word_t'(1);
    return m;
  endfunction

  function automatic word_t wr_mask_of(int idx);
    reg_attr_t a;
    a = attr_of(idx);
    return a.present ? (width_mask(int'(a.width)) & ~(a.ro | a.w1c)) : '0;
  endfunction

  function automatic word_t w1c_of(int idx);
    reg_attr_t a;
    a = attr_of(idx);
    return a.present ? (width_mask(int'(a.width)) & a.w1c) : '0;
  endfunction

  function automatic word_t rst_of(int idx);
    reg_attr_t a;
    a = attr_of(idx);
    return a.present ? (width_mask(int'(a.width)) & a.rst) : '0;
  endfunction

  function automatic logic [NUM_REGS-1:0] present_vec();
    logic [NUM_REGS-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i] = attr_of(i).present;
    return v;
  endfunction

endpackage

// File: rtl/bcsr_addr_dec.sv
module bcsr_addr_dec #(
  parameter int ADDR_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [3:0]                    be,
  input  logic                          rd,
  input  logic                          wr,
  output logic [bcsr_pkg::NUM_REGS-1:0] wr_hot,
  output logic                          rd_ok,
  output logic [bcsr_pkg::SLOT_W-1:0]   rd_idx
);
  import bcsr_pkg::*;

  localparam int OFF_W = SLOT_W + 2;
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_OFF + NUM_REGS * 4);
  localparam logic [OFF_W-1:0]  LO_O = OFF_W'(BASE_OFF);
  localparam logic [NUM_REGS-1:0] PRESENT = present_vec();

  logic             in_win;
  logic             acc_ok;
  logic [OFF_W-1:0] rel;
  logic [SLOT_W-1:0] slot;
  logic             slot_present;

  always_comb begin
    in_win = (addr >= LO_A) && (addr < HI_A);
    rel    = addr[OFF_W-1:0] - LO_O;
    slot   = rel[OFF_W-1:2];
    acc_ok = in_win && (rel[1:0] == 2'b00) && (be == 4'hF);
    slot_present = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (slot == SLOT_W'(i)) slot_present = PRESENT[i];
    end
  end

  always_comb begin
    wr_hot = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      wr_hot[i] = wr && acc_ok && PRESENT[i] && (slot == SLOT_W'(i));
    end
    rd_ok  = rd && acc_ok && slot_present;
    rd_idx = slot;
  end

  // R2: at most one register is selected per write
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hot));

  // R9: rejected byte enables never select a register
  a_r9_partial_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (be != 4'hF) |-> (wr_hot == '0 && !rd_ok));

endmodule

// File: rtl/bcsr_cell.sv
module bcsr_cell #(
  parameter int IDX = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  bcsr_pkg::word_t       wdata,
  input  bcsr_pkg::word_t       set_bits,
  output bcsr_pkg::word_t       q
);
  import bcsr_pkg::*;

  localparam word_t WR_MASK  = wr_mask_of(IDX);
  localparam word_t W1C_MASK = w1c_of(IDX);
  localparam word_t RST_VAL  = rst_of(IDX);
  localparam word_t KEEP     = ~(WR_MASK | W1C_MASK);

  word_t q_r;
  word_t q_nxt;
  word_t merged;
  word_t clr;
  word_t set_eff;
  logic  upd;

  // next-state: merge writable bits, clear W1C ones, then apply events
  always_comb begin
    set_eff = set_bits & W1C_MASK;
    merged  = wr_en ? ((q_r & ~WR_MASK) | (wdata & WR_MASK)) : q_r;
    clr     = wr_en ? (wdata & W1C_MASK) : '0;
    q_nxt   = (merged & ~clr) | set_eff;
    upd     = wr_en | (|set_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= RST_VAL;
    else if (upd) q_r <= q_nxt;
  end

  assign q = q_r;

  // R3: bits that are neither writable nor W1C never move
  a_r3_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_r & KEEP) == ($past(q_r) & KEEP)));

  generate
    if (W1C_MASK != '0) begin : g_w1c_chk
      // R4: a written 1 on a W1C bit clears it unless an event lands too
      a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q_r & $past(wdata & W1C_MASK & ~set_bits)) == '0));
      // R5: an event always leaves its bit set
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_bits & W1C_MASK)) |=>
          ((q_r & $past(set_bits & W1C_MASK)) == $past(set_bits & W1C_MASK)));
    end
  endgenerate

endmodule

// File: rtl/bcsr_irq.sv
module bcsr_irq #(
  parameter int W = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  output logic         irq
);
  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = |(pend & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: rtl/bridge_csr_bank.sv
module bridge_csr_bank #(
  parameter int ADDR_W = 9,
  parameter int EVT_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [EVT_W-1:0]  evt_set,
  output logic              irq
);
  import bcsr_pkg::*;

  localparam logic [NUM_REGS-1:0] PRESENT = present_vec();
  localparam int IRQ_W = EVT_W;

  logic [NUM_REGS-1:0] wr_hot;
  logic                rd_ok;
  logic [SLOT_W-1:0]   rd_idx;
  word_t               regs [NUM_REGS];
  word_t               evt_word;
  word_t               rdata_d;
  word_t               rdata_q;

  assign evt_word = word_t'(evt_set);

  bcsr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr),
    .be     (reg_be),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .wr_hot (wr_hot),
    .rd_ok  (rd_ok),
    .rd_idx (rd_idx)
  );

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      if (PRESENT[g]) begin : g_cell
        bcsr_cell #(.IDX(g)) u_cell (
          .clk      (clk),
          .rst_n    (rst_n),
          .wr_en    (wr_hot[g]),
          .wdata    (reg_wdata),
          .set_bits ((g == IDX_PEND) ? evt_word : '0),
          .q        (regs[g])
        );
      end else begin : g_hole
        assign regs[g] = '0;
      end
    end
  endgenerate

  bcsr_irq #(.W(IRQ_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (regs[IDX_PEND][IRQ_W-1:0]),
    .en    (regs[IDX_EN][IRQ_W-1:0]),
    .irq   (irq)
  );

  // read mux
  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_ok && rd_idx == SLOT_W'(i)) rdata_d = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  // R6: irq is pending AND enable one edge late
  a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(regs[IDX_PEND][IRQ_W-1:0] & regs[IDX_EN][IRQ_W-1:0]))));

  // R7: read data holds without a read strobe
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R8/R9: rejected or empty reads return zero
  a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !rd_ok) |=> (reg_rdata == '0));

endmodule

// File: tb/sim_bridge_csr_bank.sv
`timescale 1ns/1ps
module sim_bridge_csr_bank;

  localparam int ADDR_W = 9;
  localparam int EVT_W  = 29;

  typedef struct packed {
    logic [8:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  // write d to a, read back, expect e (state carries over between rows)
  localparam vec_t VT [NV] = '{
    '{9'h130, 32'hFFFF_FFFF, 32'h0007_0007, 4'd3},  // R3 identity fully RO
    '{9'h134, 32'hFFFF_FFFF, 32'h0003_0100, 4'd3},  // R3 control/status
    '{9'h134, 32'h0000_0000, 32'h0000_0000, 4'd3},
    '{9'h13C, 32'hFFFF_FFFF, 32'h1FF3_0FEF, 4'd3},  // R3 enable
    '{9'h140, 32'hFFFF_FFFF, 32'h00FF_FFFF, 4'd3},  // R3 width truncation
    '{9'h140, 32'h1234_5678, 32'h0034_5678, 4'd3},
    '{9'h144, 32'hFFFF_FFFF, 32'h003F_0800, 4'd3},  // R3 link keeps RO 0x800
    '{9'h144, 32'h0000_0000, 32'h0000_0800, 4'd3},
    '{9'h14C, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 4'd3},
    '{9'h150, 32'h0F0F_1234, 32'h0F0F_1234, 4'd3},
    '{9'h148, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},  // R8 hole
    '{9'h154, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},
    '{9'h15C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},
    '{9'h138, 32'hFFFF_FFFF, 32'h0000_0000, 4'd4}   // R4 nothing pending
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [3:0]        reg_be = 4'hF;
  logic              reg_rd = 1'b0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [EVT_W-1:0]  evt_set = '0;
  logic              irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bridge_csr_bank #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_set(evt_set), .irq(irq)
  );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr32(input logic [8:0] a, input logic [31:0] d,
                      input logic [3:0] b = 4'hF);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = b; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'hF;
  endtask

  task automatic rd32(input logic [8:0] a, output logic [31:0] d,
                      input logic [3:0] b = 4'hF);
    @(negedge clk);
    reg_addr = a; reg_be = b; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; reg_be = 4'hF;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [EVT_W-1:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
    rd32(9'h130, r); chk("R1", "identity", r, 32'h0007_0007);
    rd32(9'h144, r); chk("R1", "link", r, 32'h0000_0800);
    rd32(9'h138, r); chk("R1", "pending", r, 32'h0);
    rd32(9'h13C, r); chk("R1", "enable", r, 32'h0);
    rd32(9'h14C, r); chk("R1", "msi low", r, 32'h0);

    // R2/R3/R4/R8 vector walk
    for (int i = 0; i < NV; i++) begin
      string t;
      t = (VT[i].rq == 4'd8) ? "R8" : ((VT[i].rq == 4'd4) ? "R4" : "R3");
      wr32(VT[i].a, VT[i].d);
      rd32(VT[i].a, r);
      chk(t, $sformatf("R2 vector %0d", i), r, VT[i].e);
    end
    rd32(9'h14C, r); chk("R2", "msi low kept", r, 32'hA5A5_5A5A);
    chk("R6", "irq low with nothing pending", {31'b0, irq}, 32'h0);

    // R5/R6 event sets bit 0, irq one edge later
    pulse(29'h1);
    chk("R6", "irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6", "irq raised", {31'b0, irq}, 32'h1);
    rd32(9'h138, r); chk("R5", "event set bit0", r, 32'h1);
    pulse(29'h10);  // bit 4 is read-only in pending
    rd32(9'h138, r); chk("R5", "RO event ignored", r, 32'h1);

    // R4 W1C
    wr32(9'h138, 32'h0);
    rd32(9'h138, r); chk("R4", "write 0 keeps", r, 32'h1);
    wr32(9'h138, 32'h1);
    chk("R6", "irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6", "irq dropped", {31'b0, irq}, 32'h0);
    rd32(9'h138, r); chk("R4", "write 1 clears", r, 32'h0);

    // R5 set beats clear in the same cycle
    @(negedge clk);
    reg_addr = 9'h138; reg_wdata = 32'h1; reg_wr = 1'b1; evt_set = 29'h1;
    @(negedge clk);
    reg_wr = 1'b0; evt_set = '0;
    rd32(9'h138, r); chk("R5", "set wins", r, 32'h1);
    chk("R6", "irq after set", {31'b0, irq}, 32'h1);

    // R6 masking
    wr32(9'h13C, 32'h0);
    chk("R6", "irq before mask effect", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6", "irq masked", {31'b0, irq}, 32'h0);
    wr32(9'h138, 32'hFFFF_FFFF);

    // R7 hold and read-during-write
    rd32(9'h14C, r); chk("R7", "read", r, 32'hA5A5_5A5A);
    reg_addr = 9'h150;
    @(negedge clk);
    chk("R7", "hold without strobe", reg_rdata, 32'hA5A5_5A5A);
    reg_addr = 9'h140; reg_wdata = 32'h00AB_CDEF; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R7", "read during write is old", reg_rdata, 32'h0034_5678);
    rd32(9'h140, r); chk("R7", "new value after", r, 32'h00AB_CDEF);

    // R8 outside window and misaligned
    rd32(9'h12C, r); chk("R8", "below window", r, 32'h0);
    rd32(9'h160, r); chk("R8", "above window", r, 32'h0);
    rd32(9'h131, r); chk("R8", "misaligned read", r, 32'h0);
    wr32(9'h141, 32'hFFFF_FFFF);
    rd32(9'h140, r); chk("R8", "misaligned write ignored", r, 32'h00AB_CDEF);

    // R9 partial accesses
    wr32(9'h140, 32'h0, 4'h3);
    rd32(9'h140, r); chk("R9", "partial write ignored", r, 32'h00AB_CDEF);
    rd32(9'h140, r, 4'h1); chk("R9", "partial read zero", r, 32'h0);

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd32(9'h140, r); chk("R1", "bus position cleared", r, 32'h0);
    rd32(9'h144, r); chk("R1", "link reset value", r, 32'h0000_0800);
    chk("R1", "irq after reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule